// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Transmitter

This block sends stereo sample pairs as a serial bit stream on a data line, together with a bit clock and a left/right frame clock. A packed 8-bit control word chooses the framing (right-justified, left-justified, I2S with a one-bit delay, or DSP with a frame-sync pulse), the word length (16, 20, 24 or 32 bits), the frame clock phase and a channel swap. The same word decides whether the block generates the bit and frame clocks from its system clock (master) or follows clocks that arrive on input pins (slave). The data line is driven only while the activation bit is set.

Each frame is 64 bit periods long: two 32-bit channel slots. In master mode the bit clock is a register toggled every `BCLK_HALF` system cycles. In slave mode the external clocks first pass through a synchronizer, and the block then tracks them. Data and the frame clock change when the bit clock falls, so that a receiver can sample on the rising edge. Sample pairs enter through a valid/ready handshake into a single holding slot, which is consumed at the start of every frame. If the slot is empty at that point, the previous pair is sent again and an underrun flag is raised for one cycle.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is held, and in the cycle after it, bclk_o, lrclk_o, sd_o and underrun_o are 0 and s_ready_o is 1.
- R2: With cfg_i[6]=1 (master), bclk_o starts low after reset and toggles every BCLK_HALF cycles, and clk_drive_o is 1. With cfg_i[6]=0, bclk_o is 0 from the next cycle on, lrclk_o is 0 and clk_drive_o is 0.
- R3: With cfg_i[1:0]=00 (right-justified), the word in each 32-bit slot ends at the slot's last bit, MSB first. The leading unused bits are 0.
- R4: With cfg_i[1:0]=01 (left-justified), the word's MSB is the first bit of the slot. The bits after the LSB are 0.
- R5: With cfg_i[1:0]=10 (I2S), the MSB is on the second bit of the slot. The first bit and any bits past the LSB are 0.
- R6: With cfg_i[1:0]=11 (DSP), the left word and then the right word follow each other with no gap. The first word starts at frame bit 0 when cfg_i[4]=1 and at frame bit 1 when cfg_i[4]=0. Bits after the second word, or past frame bit 63, are 0.
- R7: cfg_i[3:2] sets the word length: 00=16, 01=20, 10=24, 11=32 bits. The low bits of each 32-bit sample are used.
- R8: With cfg_i[5]=1, the right sample goes in the slot (or first DSP word) that would otherwise carry the left sample, and the other way round.
- R9: In the non-DSP formats, lrclk_o equals cfg_i[4] during the left slot and its inverse during the right slot. In DSP, lrclk_o is high only during frame bit 0.
- R10: In master mode, sd_o and lrclk_o change only in the cycle in which bclk_o falls. The format fields cfg_i[5:0] take effect at the next frame start.
- R11: With cfg_i[7]=0, sd_o is 0.
- R12: s_ready_o is 1 exactly when the holding slot is empty. A pair accepted with s_valid_i & s_ready_o is the one sent in the next frame.
- R13: When a frame starts with an empty holding slot, the previous pair is repeated and underrun_o is 1 for exactly the following cycle.
- R14: In slave mode, a frame starts at the external bit-clock fall where lrclk_i enters the left level (rises, in DSP), or after 64 bits without such an edge. Outputs update SYNC_STAGES+1 cycles after the external falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | 8 | Control: [1:0] format, [3:2] word length, [4] phase, [5] swap, [6] master, [7] active |
| s_valid_i | input | 1 | Sample pair valid |
| s_ready_o | output | 1 | Holding slot empty, pair will be accepted |
| s_left_i | input | 32 | Left sample, LSB-aligned |
| s_right_i | input | 32 | Right sample, LSB-aligned |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrclk_o | output | 1 | Generated frame clock (master mode) |
| clk_drive_o | output | 1 | High while the block drives its clock outputs |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: frame started with no new pair |

## Verification
In master mode, sd_o and lrclk_o are due in the same cycle in which bclk_o falls, underrun_o is due one cycle after the frame-start edge, and s_ready_o falls one cycle after an accept. In slave mode, every output reaction is due SYNC_STAGES+1 cycles after the external bit clock falls. The bench model advances its own divider, synchronizer history and frame position on each rising edge, with the same cycle counts. It then compares every output 1 ns after that edge, when registers have settled and no input is changing. Each frame is rebuilt as a 64-entry bit array from the requirement rules at frame start, so the sampled bit for any position is known in advance.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   localparam int SLOT_BITS  = 32;
   localparam int FRAME_BITS = 2 * SLOT_BITS;
   localparam int POS_W      = $clog2(FRAME_BITS);

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_DSP = 2'b11
   } fmt_e;

   // framing part of the control word, latched at each frame start
   typedef struct packed {
      logic       swap;
      logic       phase;
      logic [1:0] wlen;
      fmt_e       fmt;
   } fmt_cfg_t;

   typedef struct packed {
      logic     active;
      logic     master;
      fmt_cfg_t fc;
   } cfg_t;

   function automatic int word_bits(logic [1:0] wl);
      return (wl == 2'b11) ? 32 : 16 + 4 * int'(wl);
   endfunction

   // serial bit for frame position p
   function automatic logic slot_bit(fmt_cfg_t c, logic [31:0] l, logic [31:0] r,
                                     logic [POS_W-1:0] p);
      int          w, q, k;
      logic [31:0] a, b, s;
      logic        res;
      w   = word_bits(c.wlen);
      a   = c.swap ? r : l;
      b   = c.swap ? l : r;
      res = 1'b0;
      if (c.fmt == FMT_DSP) begin
         k = int'(p) - (c.phase ? 0 : 1);
         if (k >= 0 && k < w)           res = a[5'(w - 1 - k)];
         else if (k >= w && k < 2 * w)  res = b[5'(2 * w - 1 - k)];
      end else begin
         s = p[POS_W-1] ? b : a;
         q = int'(p[POS_W-2:0]);
         case (c.fmt)
            FMT_LJ:  if (q < w)             res = s[5'(w - 1 - q)];
            FMT_I2S: if (q >= 1 && q <= w)  res = s[5'(w - q)];
            default: if (31 - q < w)        res = s[5'(31 - q)];
         endcase
      end
      return res;
   endfunction

   function automatic logic lr_level(fmt_cfg_t c, logic [POS_W-1:0] p);
      if (c.fmt == FMT_DSP) return (p == '0);
      return p[POS_W-1] ? ~c.phase : c.phase;
   endfunction

endpackage

// File: rtl/aud_ser_bclk_gen.sv
module aud_ser_bclk_gen #(
   parameter int BCLK_HALF = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic en_i,
   output logic bclk_o,
   output logic fall_o
);
   localparam int CW = $clog2(BCLK_HALF);
   localparam logic [CW-1:0] LAST = CW'(BCLK_HALF - 1);

   logic [CW-1:0] cnt;
   logic          bclk_q;

   always_ff @(posedge clk) begin
      if (rst || !en_i) begin
         cnt    <= '0;
         bclk_q <= 1'b0;
      end else if (cnt == LAST) begin
         cnt    <= '0;
         bclk_q <= ~bclk_q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign bclk_o = bclk_q;
   assign fall_o = en_i & bclk_q & (cnt == LAST);
endmodule

// File: rtl/aud_ser_sync.sv
module aud_ser_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic bclk_i,
   input  logic lrclk_i,
   output logic fall_o,
   output logic lr_o
);
   logic [STAGES-1:0] bq, lq;
   logic              bprev;

   always_ff @(posedge clk) begin
      if (rst) begin
         bq    <= '0;
         lq    <= '0;
         bprev <= 1'b0;
      end else begin
         bq    <= {bq[STAGES-2:0], bclk_i};
         lq    <= {lq[STAGES-2:0], lrclk_i};
         bprev <= bq[STAGES-1];
      end
   end

   assign fall_o = bprev & ~bq[STAGES-1];
   assign lr_o   = lq[STAGES-1];
endmodule

// File: rtl/aud_ser_buf.sv
module aud_ser_buf #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          valid_i,
   output logic          ready_o,
   input  logic [DW-1:0] l_i,
   input  logic [DW-1:0] r_i,
   input  logic          take_i,
   output logic          full_o,
   output logic [DW-1:0] l_o,
   output logic [DW-1:0] r_o
);
   logic full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         l_o    <= '0;
         r_o    <= '0;
      end else if (valid_i && !full_q) begin
         full_q <= 1'b1;
         l_o    <= l_i;
         r_o    <= r_i;
      end else if (take_i) begin
         full_q <= 1'b0;
      end
   end

   assign ready_o = ~full_q;
   assign full_o  = full_q;
endmodule

// File: rtl/aud_ser_frame.sv
module aud_ser_frame
   import aud_ser_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     fall_i,
   input  logic     master_i,
   input  logic     lr_s_i,
   input  fmt_cfg_t fc_i,
   input  logic     pend_full_i,
   input  logic [31:0] pend_l_i,
   input  logic [31:0] pend_r_i,
   output logic     frame_start_o,
   output logic     sd_o,
   output logic     lr_o,
   output logic     underrun_o
);
   logic [POS_W-1:0] pos;
   fmt_cfg_t         fc_l;
   logic [31:0]      cur_l, cur_r, nxt_l, nxt_r;
   logic             lr_last, ext_edge;

   assign ext_edge = (fc_i.fmt == FMT_DSP) ? (lr_s_i & ~lr_last)
                   : ((lr_s_i == fc_i.phase) && (lr_last != fc_i.phase));
   assign frame_start_o = fall_i & ((pos == POS_W'(FRAME_BITS - 1)) | (~master_i & ext_edge));
   assign nxt_l = pend_full_i ? pend_l_i : cur_l;
   assign nxt_r = pend_full_i ? pend_r_i : cur_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos        <= POS_W'(FRAME_BITS - 1);
         fc_l       <= '0;
         cur_l      <= '0;
         cur_r      <= '0;
         sd_o       <= 1'b0;
         lr_o       <= 1'b0;
         lr_last    <= 1'b0;
         underrun_o <= 1'b0;
      end else begin
         underrun_o <= frame_start_o & ~pend_full_i;
         if (fall_i) begin
            lr_last <= lr_s_i;
            if (frame_start_o) begin
               fc_l  <= fc_i;
               cur_l <= nxt_l;
               cur_r <= nxt_r;
               pos   <= '0;
               sd_o  <= slot_bit(fc_i, nxt_l, nxt_r, '0);
               lr_o  <= master_i & lr_level(fc_i, '0);
            end else begin
               pos   <= pos + 1'b1;
               sd_o  <= slot_bit(fc_l, cur_l, cur_r, pos + 1'b1);
               lr_o  <= master_i & lr_level(fc_l, pos + 1'b1);
            end
         end
      end
   end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_ser_pkg::*;
#(
   parameter int BCLK_HALF   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [7:0]  cfg_i,
   input  logic        s_valid_i,
   output logic        s_ready_o,
   input  logic [31:0] s_left_i,
   input  logic [31:0] s_right_i,
   input  logic        bclk_i,
   input  logic        lrclk_i,
   output logic        bclk_o,
   output logic        lrclk_o,
   output logic        clk_drive_o,
   output logic        sd_o,
   output logic        underrun_o
);
   generate
      if (BCLK_HALF < 2) begin : g_bad_half
         $error("BCLK_HALF must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   cfg_t        cfg;
   logic        m_fall, s_fall, s_lr, fall, take, pend_full;
   logic [31:0] pend_l, pend_r;
   logic        sd_q, lr_q;

   assign cfg  = cfg_t'(cfg_i);
   assign fall = cfg.master ? m_fall : s_fall;

   aud_ser_bclk_gen #(.BCLK_HALF(BCLK_HALF)) u_bclk (
      .clk(clk), .rst(rst), .en_i(cfg.master), .bclk_o(bclk_o), .fall_o(m_fall));

   aud_ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
      .fall_o(s_fall), .lr_o(s_lr));

   aud_ser_buf #(.DW(32)) u_buf (
      .clk(clk), .rst(rst), .valid_i(s_valid_i), .ready_o(s_ready_o),
      .l_i(s_left_i), .r_i(s_right_i), .take_i(take),
      .full_o(pend_full), .l_o(pend_l), .r_o(pend_r));

   aud_ser_frame u_frame (
      .clk(clk), .rst(rst), .fall_i(fall), .master_i(cfg.master), .lr_s_i(s_lr),
      .fc_i(cfg.fc), .pend_full_i(pend_full), .pend_l_i(pend_l), .pend_r_i(pend_r),
      .frame_start_o(take), .sd_o(sd_q), .lr_o(lr_q), .underrun_o(underrun_o));

   assign lrclk_o     = cfg.master & lr_q;
   assign sd_o        = cfg.active & sd_q;
   assign clk_drive_o = cfg.master;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk #(
   parameter int BCLK_HALF = 4
) (
   input logic clk,
   input logic rst,
   input logic master_i,
   input logic active_i,
   input logic bclk_o,
   input logic sd_o,
   input logic s_valid_i,
   input logic s_ready_o,
   input logic underrun_o
);
   AST_SLAVE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
      !master_i |=> !bclk_o); // R2

   generate
      if (BCLK_HALF > 1) begin : g_hold
         AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
            (master_i && $past(master_i) && !$stable(bclk_o)) |=> (!master_i || $stable(bclk_o))); // R2
      end
   endgenerate

   AST_SD_AT_FALL: assert property (@(posedge clk) disable iff (rst)
      (master_i && $past(master_i) && active_i && $past(active_i) && !$stable(sd_o))
      |-> $fell(bclk_o)); // R10

   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
      (s_valid_i && s_ready_o) |=> !s_ready_o); // R12

   AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
      underrun_o |=> !underrun_o); // R13
endmodule

bind aud_ser_tx aud_ser_tx_chk #(.BCLK_HALF(BCLK_HALF)) u_chk (
   .clk(clk), .rst(rst), .master_i(cfg_i[6]), .active_i(cfg_i[7]),
   .bclk_o(bclk_o), .sd_o(sd_o), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
   .underrun_o(underrun_o));

// File: tb/aud_ser_tx_test.sv
`timescale 1ns/1ps
module aud_ser_tx_test;
   localparam int H  = 4;
   localparam int SH = 6;     // half period of external bit clock in slave tests

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  cfg_i = 8'h00;
   logic        s_valid_i = 1'b0;
   logic [31:0] s_left_i = '0, s_right_i = '0;
   logic        bclk_i = 1'b0, lrclk_i = 1'b0;
   logic        s_ready_o, bclk_o, lrclk_o, clk_drive_o, sd_o, underrun_o;

   aud_ser_tx #(.BCLK_HALF(H), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .cfg_i(cfg_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
      .s_left_i(s_left_i), .s_right_i(s_right_i), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
      .bclk_o(bclk_o), .lrclk_o(lrclk_o), .clk_drive_o(clk_drive_o), .sd_o(sd_o),
      .underrun_o(underrun_o));

   always #2.5 clk = ~clk;

   int n_vec = 0, n_bad = 0, cycles = 0;

   // ---------------- reference model ----------------
   int          mcnt = 0, pos = 63;
   bit          mb = 0, bprev = 0, lr_last = 0, sdr = 0, lrr = 0, und = 0, acc = 0;
   bit   [1:0]  bsh = 0, lsh = 0;
   bit   [31:0] cur_l = 0, cur_r = 0;
   bit   [63:0] pendq[$];
   bit          fb[64], flr[64];

   function automatic int wbits(bit [1:0] wl);
      case (wl) 2'd0: return 16; 2'd1: return 20; 2'd2: return 24; default: return 32; endcase
   endfunction

   task automatic build(bit [7:0] c);
      int w, d, st, idx;
      bit [31:0] a, b, word;
      w = wbits(c[3:2]);
      a = c[5] ? cur_r : cur_l;
      b = c[5] ? cur_l : cur_r;
      for (int p = 0; p < 64; p++) begin
         fb[p]  = 0;
         flr[p] = (c[1:0] == 2'd3) ? (p == 0) : ((p < 32) ? c[4] : !c[4]);
      end
      if (c[1:0] == 2'd3) begin
         d = c[4] ? 0 : 1;
         for (int k = 0; k < 2 * w; k++) begin
            idx = d + k;
            if (idx < 64) fb[idx] = (k < w) ? a[w-1-k] : b[2*w-1-k];
         end
      end else begin
         for (int s = 0; s < 2; s++) begin
            word = s ? b : a;
            st = (c[1:0] == 2'd0) ? 32*s + 32 - w : (c[1:0] == 2'd1) ? 32*s : 32*s + 1;
            for (int k = 0; k < w; k++)
               if (st + k < 32*s + 32) fb[st+k] = word[w-1-k];
         end
      end
   endtask

   always @(posedge clk) begin
      bit m, rdy, mfall, sfall, lrs, fall, edg, fs;
      cycles++;
      if (rst) begin
         mcnt = 0; mb = 0; bsh = 0; lsh = 0; bprev = 0; pos = 63; lr_last = 0;
         cur_l = 0; cur_r = 0; pendq.delete(); sdr = 0; lrr = 0; und = 0; acc = 0;
      end else begin
         m   = cfg_i[6];
         rdy = (pendq.size() == 0);
         acc = s_valid_i && rdy;
         mfall = m && (mcnt == H-1) && mb;
         if (!m) begin mcnt = 0; mb = 0; end
         else if (mcnt == H-1) begin mcnt = 0; mb = !mb; end
         else mcnt++;
         sfall = bprev && !bsh[1];
         lrs   = lsh[1];
         bprev = bsh[1];
         bsh   = {bsh[0], bclk_i};
         lsh   = {lsh[0], lrclk_i};
         fall  = m ? mfall : sfall;
         edg   = (cfg_i[1:0] == 2'd3) ? (lrs && !lr_last) : (lrs == cfg_i[4] && lr_last != cfg_i[4]);
         fs    = fall && (pos == 63 || (!m && edg));
         und   = fs && rdy;
         if (fall) begin
            lr_last = lrs;
            if (fs) begin
               if (!rdy) {cur_l, cur_r} = pendq.pop_front();
               build(cfg_i);
               pos = 0;
            end else pos++;
            sdr = fb[pos];
            lrr = m && flr[pos];
         end
         if (acc) pendq.push_back({s_left_i, s_right_i});
      end
   end

   // ---------------- comparison ----------------
   function automatic string sd_tag();
      string t;
      if (rst) return "R1";
      if (!cfg_i[7]) return "R11";
      if (!cfg_i[6]) return "R14";
      case (cfg_i[1:0]) 2'd0: t = "R3"; 2'd1: t = "R4"; 2'd2: t = "R5"; default: t = "R6"; endcase
      t = {t, "/R7/R10"};
      if (cfg_i[5]) t = {t, "/R8"};
      return t;
   endfunction

   task automatic chk1(string tag, string sig, bit act, bit exp);
      if (act !== exp) begin
         n_bad++;
         if (n_bad < 25)
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, sig, cycles, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #1;
      n_vec++;
      chk1(rst ? "R1" : "R2", "bclk_o", bclk_o, mb);
      chk1(rst ? "R1" : "R2", "clk_drive_o", clk_drive_o, cfg_i[6]);
      chk1(rst ? "R1" : (cfg_i[6] ? "R9" : "R2"), "lrclk_o", lrclk_o, cfg_i[6] && lrr);
      chk1(sd_tag(), "sd_o", sd_o, cfg_i[7] && sdr);
      chk1(rst ? "R1" : "R12", "s_ready_o", s_ready_o, pendq.size() == 0);
      chk1(rst ? "R1" : "R13", "underrun_o", underrun_o, und);
      if (cycles > 190000) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): actual=%0d cycles expected<190000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   // ---------------- sample source ----------------
   bit        feed_en = 0;
   bit [31:0] seed = 32'h1234_5678;
   always @(negedge clk) begin
      if (feed_en) begin
         if (acc || !s_valid_i) begin
            seed      = seed * 32'd1103515245 + 32'd12345;
            s_left_i  = seed ^ 32'hA5C3_0F96;
            s_right_i = {seed[15:0], seed[31:16]} ^ 32'h3C69_E21B;
         end
         s_valid_i = 1'b1;
      end else s_valid_i = 1'b0;
   end

   // ---------------- external clock source (slave, R14) ----------------
   bit gen_en = 0, gb = 0;
   int gcnt = 0, gpos = 0;
   always @(negedge clk) begin
      if (gen_en) begin
         if (gcnt == SH-1) begin
            gcnt = 0;
            if (gb) begin
               gpos    = (gpos + 1) % 64;
               lrclk_i = (cfg_i[1:0] == 2'd3) ? (gpos == 0) : ((gpos < 32) ? cfg_i[4] : !cfg_i[4]);
            end
            gb = !gb;
            bclk_i = gb;
         end else gcnt++;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_cyc(5);                         // R1 reset state compared each cycle
      rst = 1'b0;
      feed_en = 1;
      // master mode sweep: R3..R10, R12
      for (int f = 0; f < 4; f++)
         for (int wl = 0; wl < 4; wl++)
            for (int ph = 0; ph < 2; ph++) begin
               cfg_i = {1'b1, 1'b1, 1'((f + wl + ph) % 2), 1'(ph), 2'(wl), 2'(f)};
               wait_cyc(2 * 64 * 2 * H);
            end
      // R11: inactive data line
      cfg_i = 8'b0100_0110;
      wait_cyc(700);
      // R13: starve the source
      cfg_i = 8'b1100_1001;
      feed_en = 0;
      wait_cyc(1300);
      feed_en = 1;
      wait_cyc(1300);
      // R14: slave mode, external clocks
      gen_en = 1;
      for (int f = 0; f < 4; f++) begin
         cfg_i = {1'b1, 1'b0, 1'(f % 2), 1'(f / 2), 2'(3 - f), 2'(f)};
         wait_cyc(3 * 64 * 2 * SH);
      end
      gen_en = 0;
      // back to master (R2)
      cfg_i = 8'b1110_0010;
      wait_cyc(1200);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule